// File: doc/BRIEF.md
# Timer Capture Channel with Overwrite Detection

This block is one capture channel that sits beside a 16-bit timer counter. It watches one trigger signal, which is either an external pin or a trigger level driven by software. When the chosen edge of that signal arrives while the counter is running, the channel copies the live counter value into its capture holder and raises a capture flag. Software reads the stored value to measure event periods or pulse widths, usually as the difference between two captures.

If a new capture arrives before software has cleared the capture flag, the holder is still loaded with the newer value. A separate overwrite flag is then raised so that software knows one sample was lost. Each flag has its own interrupt enable, and the interrupt request is raised when any enabled flag is set. The external pin passes through a two-stage synchronizer before edge detection. The software trigger is taken as a level that is already synchronous to the clock.

Access is through a small word-wide register port with a combinational read path. Address 0 holds the configuration. Address 1 holds the flags, which are cleared by writing 1. Address 2 returns the captured value.

Top module: `tcap_channel`

## Requirements
- R1: After reset the captured value, both flags and the interrupt request are 0, and the configuration reads back as 0.
- R2: With source 0 (external pin), a pin change first seen at clock edge k loads the counter value present at edge k+2 into the holder, and the result is visible after edge k+2 and not before. Any value from 0x0000 to 0xffff is stored exactly.
- R3: Edge field values: 0 = never capture, 1 = rising only, 2 = falling only, 3 = both rising and falling.
- R4: With source 1 (software trigger), a change of the trigger level first seen at edge k captures at edge k.
- R5: Source values 2 and 3 never cause a capture, whatever the pin and the software trigger do.
- R6: No capture occurs in a cycle in which the counter-running input is low.
- R7: The capture flag (flags bit 0) is set on the same edge that loads the holder.
- R8: A capture that arrives while the capture flag is already set replaces the held value and sets the overwrite flag (flags bit 1).
- R9: Writing to address 1 clears each flag whose bit is 1 in the written data. A 0 bit leaves its flag unchanged.
- R10: When a capture and a clear of the same flag fall on the same edge, the flag ends up set.
- R11: The interrupt request is (capture flag AND config bit 4) OR (overwrite flag AND config bit 5).
- R12: Config layout at address 0: bits [1:0] source, [3:2] edge, [4] capture interrupt enable, [5] overwrite interrupt enable. It reads back as written. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Live counter value |
| cnt_run | input | 1 | High while the counter is counting |
| cap_pin | input | 1 | External capture input, asynchronous |
| sw_trig | input | 1 | Software trigger level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| cap_data | output | 16 | Captured counter value |
| cap_flag | output | 1 | Capture-complete flag |
| ow_flag | output | 1 | Overwrite-error flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are a capture that lands on exactly the edge where software writes a clear, and a second capture that arrives while the first one is still unread. In both, the trigger and the write have to meet on one clock edge. The bench uses the software trigger for these cases because its latency is a single edge. That lets it raise the trigger level and the clear strobe in the same half cycle, both with and without the capture flag already set. A sweep over every combination of source, edge mode, edge direction and run state covers the selection logic. The pin latency is measured edge by edge.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  typedef enum logic [1:0] {
    SRC_PIN  = 2'd0,
    SRC_SOFT = 2'd1,
    SRC_RSV2 = 2'd2,
    SRC_RSV3 = 2'd3
  } trig_src_e;

  // Configuration word, MSB first: ow_ie, cap_ie, edge, source
  typedef struct packed {
    logic       ow_ie;
    logic       cap_ie;
    edge_mode_e edge_md;
    trig_src_e  src;
  } cap_cfg_t;

  localparam int CFG_W = $bits(cap_cfg_t);

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tcap_trig.sv
module tcap_trig
  import tcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s,
  input  logic       sw_lvl,
  input  trig_src_e  src,
  input  edge_mode_e edge_md,
  input  logic       run,
  output logic       evt
);
  logic pin_prev_q;
  logic sw_prev_q;
  logic rise;
  logic fall;
  logic hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev_q <= 1'b0;
      sw_prev_q  <= 1'b0;
    end else begin
      pin_prev_q <= pin_s;
      sw_prev_q  <= sw_lvl;
    end
  end

  always_comb begin
    rise = 1'b0;
    fall = 1'b0;
    case (src)
      SRC_PIN: begin
        rise = pin_s & ~pin_prev_q;
        fall = ~pin_s & pin_prev_q;
      end
      SRC_SOFT: begin
        rise = sw_lvl & ~sw_prev_q;
        fall = ~sw_lvl & sw_prev_q;
      end
      default: begin
        rise = 1'b0;
        fall = 1'b0;
      end
    endcase
  end

  always_comb begin
    case (edge_md)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  assign evt = run & hit;
endmodule

// File: rtl/tcap_store.sv
module tcap_store #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [CNT_W-1:0] cnt,
  input  logic             clr_cap,
  input  logic             clr_ow,
  output logic [CNT_W-1:0] data,
  output logic             cap_flag,
  output logic             ow_flag
);
  logic [CNT_W-1:0] data_q;
  logic             cap_q, cap_d;
  logic             ow_q, ow_d;

  // A set from a new capture wins over a clear in the same cycle
  always_comb begin
    cap_d = evt | (cap_q & ~clr_cap);
    ow_d  = (evt & cap_q) | (ow_q & ~clr_ow);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data_q <= '0;
    else if (evt) data_q <= cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 1'b0;
      ow_q  <= 1'b0;
    end else begin
      cap_q <= cap_d;
      ow_q  <= ow_d;
    end
  end

  assign data     = data_q;
  assign cap_flag = cap_q;
  assign ow_flag  = ow_q;
endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
  import tcap_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_run,
  input  logic             cap_pin,
  input  logic             sw_trig,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic [CNT_W-1:0] cap_data,
  output logic             cap_flag,
  output logic             ow_flag,
  output logic             irq
);
  localparam int RST_STAGES = 2;

  // Reset: asserted asynchronously, released on a clock edge
  logic [RST_STAGES-1:0] rst_sh_q;
  logic                  rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sh_q[RST_STAGES-1];

  // Configuration register
  cap_cfg_t cfg_q;
  cap_cfg_t cfg_d;
  logic     cfg_we;
  logic     flag_we;
  logic     cap_evt;
  logic     pin_s;
  logic     unused_wdata;

  assign cfg_we       = reg_wr & (reg_addr == ADDR_CFG);
  assign flag_we      = reg_wr & (reg_addr == ADDR_FLAG);
  assign cfg_d        = cap_cfg_t'(reg_wdata[CFG_W-1:0]);
  assign unused_wdata = ^reg_wdata[CNT_W-1:CFG_W];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  cfg_q <= '0;
    else if (cfg_we)  cfg_q <= cfg_d;
  end

  tcap_sync #(.STAGES(SYNC_DEPTH)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (cap_pin),
    .q     (pin_s)
  );

  tcap_trig u_trig (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .pin_s   (pin_s),
    .sw_lvl  (sw_trig),
    .src     (cfg_q.src),
    .edge_md (cfg_q.edge_md),
    .run     (cnt_run),
    .evt     (cap_evt)
  );

  tcap_store #(.CNT_W(CNT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .evt      (cap_evt),
    .cnt      (cnt_val),
    .clr_cap  (flag_we & reg_wdata[0]),
    .clr_ow   (flag_we & reg_wdata[1]),
    .data     (cap_data),
    .cap_flag (cap_flag),
    .ow_flag  (ow_flag)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CFG:  reg_rdata[CFG_W-1:0] = cfg_q;
      ADDR_FLAG: reg_rdata[1:0]       = {ow_flag, cap_flag};
      ADDR_DATA: reg_rdata            = cap_data;
      default:   reg_rdata            = '0;
    endcase
  end

  assign irq = (cap_flag & cfg_q.cap_ie) | (ow_flag & cfg_q.ow_ie);
endmodule

// File: rtl/tcap_channel_chk.sv
module tcap_channel_chk
  import tcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_run,
  input logic [CNT_W-1:0] cap_data,
  input logic             cap_flag,
  input logic             ow_flag,
  input logic             irq,
  input logic             cap_evt,
  input cap_cfg_t         cfg
);
  p_run_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_run) |-> $stable(cap_data));

  p_rsv_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg.src[1]) |-> $stable(cap_data));

  p_flag_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_evt) |-> cap_flag);

  p_ow_needs_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ow_flag) |-> $past(cap_flag));

  p_ow_on_replace_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_evt && cap_flag) |-> ow_flag);

  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cap_flag || ow_flag));
endmodule

bind tcap_channel tcap_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_run  (cnt_run),
  .cap_data (cap_data),
  .cap_flag (cap_flag),
  .ow_flag  (ow_flag),
  .irq      (irq),
  .cap_evt  (cap_evt),
  .cfg      (cfg_q)
);

// File: tb/tcap_channel_tb.sv
`timescale 1ns/1ps
module tcap_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cnt_val;
  logic        cnt_run;
  logic        cap_pin;
  logic        sw_trig;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [15:0] cap_data;
  logic        cap_flag;
  logic        ow_flag;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tcap_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_run(cnt_run),
    .cap_pin(cap_pin), .sw_trig(sw_trig), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cap_data(cap_data), .cap_flag(cap_flag), .ow_flag(ow_flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] cfgw(input int ie, input int edg, input int src);
    return 16'((ie << 4) | (edg << 2) | src);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] exp_data;
    int iter;
    rst_n = 1'b0; cnt_val = '0; cnt_run = 1'b1; cap_pin = 1'b0; sw_trig = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 data", cap_data, 0);
    chk("R1 cap flag", cap_flag, 0);
    chk("R1 ow flag", ow_flag, 0);
    chk("R1 irq", irq, 0);
    rd(ADDR_CFG_TB, v); chk("R1 cfg", v, 0);

    // Sweep: run x source x edge mode x direction
    exp_data = '0;
    iter = 0;
    for (int run = 0; run < 2; run++)
      for (int src = 0; src < 4; src++)
        for (int edg = 0; edg < 4; edg++)
          for (int dir = 0; dir < 2; dir++) begin
            bit rising;
            bit fires;
            logic [15:0] val;
            string tag;
            rising = (dir == 0);
            wr(2'd0, cfgw(0, 0, 0));
            cap_pin = ~rising; sw_trig = ~rising; cnt_run = run[0];
            idle(4);
            wr(2'd1, 16'h3);
            wr(2'd0, cfgw(0, edg, src));
            val = (iter == 0) ? 16'hffff : (iter == 1) ? 16'h0000 : 16'(16'h1234 + iter * 997);
            cnt_val = val;
            @(negedge clk);
            if (src == 0)      cap_pin = rising;
            else if (src == 1) sw_trig = rising;
            else begin cap_pin = rising; sw_trig = rising; end
            idle(5);
            fires = run[0] && (src < 2) &&
                    (edg == 3 || (edg == 1 && rising) || (edg == 2 && !rising));
            if (fires) exp_data = val;
            if (run == 0)      tag = "R6 sweep";
            else if (src >= 2) tag = "R5 sweep";
            else if (src == 1) tag = "R4/R3 sweep";
            else               tag = "R2/R3 sweep";
            chk({tag, " data"}, cap_data, exp_data);
            chk({"R7 ", tag, " flag"}, cap_flag, int'(fires));
            chk({tag, " ow"}, ow_flag, 0);
            iter++;
          end

    // R2 pin latency: change seen at edge k, result after edge k+2
    cnt_run = 1'b1; cap_pin = 1'b0; sw_trig = 1'b0;
    wr(2'd0, cfgw(0, 1, 0));
    idle(4);
    wr(2'd1, 16'h3);
    cnt_val = 16'h0abc;
    @(negedge clk); cap_pin = 1'b1;
    @(negedge clk); chk("R2 latency k", cap_flag, 0);
    @(negedge clk); chk("R2 latency k+1", cap_flag, 0);
    @(negedge clk); chk("R2 latency k+2 flag", cap_flag, 1);
    chk("R2 latency k+2 data", cap_data, 16'h0abc);

    // R4 software latency: one edge
    cap_pin = 1'b0;
    wr(2'd0, cfgw(0, 1, 1));
    idle(2);
    wr(2'd1, 16'h3);
    cnt_val = 16'h5a5a;
    @(negedge clk); sw_trig = 1'b1;
    @(negedge clk); chk("R4 latency flag", cap_flag, 1);
    chk("R4 latency data", cap_data, 16'h5a5a);

    // R10 capture coincides with clear (flag was clear)
    sw_trig = 1'b0; idle(2);
    wr(2'd1, 16'h3);
    cnt_val = 16'h1111;
    @(negedge clk); sw_trig = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h1;
    @(negedge clk); reg_wr = 1'b0;
    chk("R10 set wins cap", cap_flag, 1);
    chk("R10 ow quiet", ow_flag, 0);

    // R8 overwrite while flag set
    sw_trig = 1'b0; idle(2);
    cnt_val = 16'h2222;
    @(negedge clk); sw_trig = 1'b1;
    @(negedge clk);
    chk("R8 ow set", ow_flag, 1);
    chk("R8 data replaced", cap_data, 16'h2222);

    // R10 overwrite coincides with clear of both flags
    sw_trig = 1'b0; idle(2);
    cnt_val = 16'h3333;
    @(negedge clk); sw_trig = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h3;
    @(negedge clk); reg_wr = 1'b0;
    chk("R10 cap kept", cap_flag, 1);
    chk("R10 ow kept", ow_flag, 1);
    chk("R10 data", cap_data, 16'h3333);

    // R9 write-one-to-clear
    wr(2'd1, 16'h0);
    rd(2'd1, v); chk("R9 zero write", v, 3);
    wr(2'd1, 16'h1);
    rd(2'd1, v); chk("R9 clear cap only", v, 2);
    wr(2'd1, 16'h2);
    rd(2'd1, v); chk("R9 clear ow", v, 0);

    // R11 interrupt with each enable pair, cap only then both flags
    sw_trig = 1'b0; idle(2);
    @(negedge clk); sw_trig = 1'b1;
    @(negedge clk);
    for (int ie = 0; ie < 4; ie++) begin
      wr(2'd0, cfgw(ie, 1, 1));
      chk("R11 cap only", irq, ie & 1);
      rd(2'd0, v); chk("R12 cfg readback", v, cfgw(ie, 1, 1));
    end
    sw_trig = 1'b0; idle(2);
    @(negedge clk); sw_trig = 1'b1;
    @(negedge clk);
    for (int ie = 0; ie < 4; ie++) begin
      wr(2'd0, cfgw(ie, 1, 1));
      chk("R11 both flags", irq, int'(ie != 0));
    end
    wr(2'd1, 16'h1);
    wr(2'd0, cfgw(2, 1, 1));
    chk("R11 ow only", irq, 1);

    // R12 address map
    rd(2'd2, v); chk("R12 data read", v, cap_data);
    rd(2'd3, v); chk("R12 unused addr", v, 0);
    wr(2'd0, 16'h003f);
    rd(2'd0, v); chk("R12 cfg all ones", v, 16'h003f);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [1:0] ADDR_CFG_TB = 2'd0;
endmodule